// File: doc/BRIEF.md
# Scan Test Sequencer

This block runs a structural test of a small combinational circuit that is wrapped by a chain of mux-flops. Each flop takes its functional value from the circuit when the scan enable is low. When the scan enable is high it takes the bit held by its neighbour. A controller first shifts a fixed 0011 flush sequence into the chain. The first shift phase then pushes that sequence out and checks it, which tests the chain on its own while the first stimulus goes in. After every load the controller drops the scan enable for exactly one clock so that the circuit's response is captured. It then shifts that response out while the next stimulus shifts in, and compares each bit as it leaves the chain.

An external pattern source follows the pattern index that the block puts out. For that index it presents the stimulus, the primary-input values and the known-good response. After the last capture, one more unload shifts the final response out. Then the block raises done. A mismatch sets a sticky fail flag and records which pattern failed first.

Top module: `scan_seq_top`

## Requirements
- R1: While reset is held, scan_en_o, done_o and fail_o are 0, and pat_idx_o and fail_idx_o are 0.
- R2: A start in the idle or done state begins a flush fill of CHAIN_LEN clocks with scan_en_o high. The bit shifted in at fill step k is bit 1 of k, giving 0,0,1,1 repeating.
- R3: During the first CHAIN_LEN shift clocks after the fill, the scan_out_o value at step k equals bit 1 of k. A difference counts as a mismatch under R8, recorded with index NUM_PAT.
- R4: Bits shift from chain position 0 toward position CHAIN_LEN-1, and scan_out_o is position CHAIN_LEN-1. A load of stimulus s shifts s[CHAIN_LEN-1] in first, so that afterwards position i holds s[i].
- R5: After each load, scan_en_o is low for exactly one clock. In that clock position i captures s[(i+1)%N] & pi[i%PI_W] ^ s[(i+N-1)%N]. Here s is the chain content and pi is pi_i at that clock.
- R6: Each captured response leaves at scan_out_o over the next CHAIN_LEN shift clocks, bit CHAIN_LEN-1 first, while the next stimulus loads. After the last capture a final unload of CHAIN_LEN clocks shifts in zeros.
- R7: pat_idx_o is 0 during the fill and the first load. It increases by one at the end of each capture clock and equals NUM_PAT during the final unload and afterwards.
- R8: At unload step k, scan_out_o is compared with bit CHAIN_LEN-1-k of the exp_i value sampled in the capture clock. The first mismatch sets fail_o and loads fail_idx_o with the index of the pattern being unloaded, and both then hold until the next start.
- R9: done_o rises in the clock after the final unload and stays high until the next start. In the idle and done states scan_en_o is low and the chain holds its contents.
- R10: start has no effect while a run is in progress.
- R11: A start from the done state clears fail_o, fail_idx_o and done_o and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test run when idle or done |
| stim_i | input | CHAIN_LEN | Stimulus for pattern pat_idx_o |
| pi_i | input | PI_W | Primary-input values for pattern pat_idx_o |
| exp_i | input | CHAIN_LEN | Known-good response for pattern pat_idx_o |
| scan_en_o | output | 1 | Scan enable of the chain |
| scan_out_o | output | 1 | Last bit of the chain |
| pat_idx_o | output | clog2(NUM_PAT+1) | Pattern currently being loaded or captured |
| done_o | output | 1 | Run finished |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_idx_o | output | clog2(NUM_PAT+1) | Pattern index of the first mismatch (NUM_PAT for the flush) |

## Verification
The bench builds the block with a chain of 6 flops, 3 patterns and 3 primary inputs. Because 6 is not a multiple of 4, the flush sequence stops partway through a 0011 group. The index width is exact at 2 bits, so the flush marker index 3 is the largest value it can hold. Patterns whose expected response is corrupted on purpose are placed first, in the middle and last. These positions reach the first-mismatch rule, a failure found only in the final unload, and the clearing of fail on restart.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the scan test sequencer.
package scan_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FILL,
        PH_SHIFT,
        PH_CAPT,
        PH_DONE
    } phase_t;

    // Flush sequence bit at shift step k: 0,0,1,1 repeating.
    function automatic logic flush_bit(input int unsigned k);
        return k[1];
    endfunction
endpackage

// File: rtl/scan_chain.sv
`timescale 1ns/1ps
// Chain of N mux-flops. Each flop loads functional data d when se is low.
// When se is high it loads its predecessor, and flop 0 loads si.
// Assumes en gates every update; q holds while en is low.
module scan_chain #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         se,
    input  logic         si,
    input  logic [N-1:0] d,
    output logic [N-1:0] q,
    output logic         so
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev;
        if (i == 0) begin : g_head
            assign prev = si;
        end else begin : g_body
            assign prev = q[i-1];
        end
        // Mux-flop: scan path or functional capture.
        always_ff @(posedge clk) begin
            if (!rst_n)  q[i] <= 1'b0;
            else if (en) q[i] <= se ? prev : d[i];
        end
    end

    assign so = q[N-1];
endmodule

// File: rtl/scan_cut.sv
`timescale 1ns/1ps
// Small combinational circuit under test.
// y[i] = s[i+1] & pi[i mod PW] ^ s[i-1], with indices taken modulo N.
module scan_cut #(
    parameter int N  = 8,
    parameter int PW = 4
) (
    input  logic [N-1:0]  s,
    input  logic [PW-1:0] pi,
    output logic [N-1:0]  y
);
    for (genvar i = 0; i < N; i++) begin : g_out
        localparam int NX = (i + 1) % N;
        localparam int PV = (i + N - 1) % N;
        localparam int PI = i % PW;
        assign y[i] = (s[NX] & pi[PI]) ^ s[PV];
    end
endmodule

// File: rtl/scan_ctrl.sv
`timescale 1ns/1ps
// Sequencer: fill -> (shift N, capture 1) x P -> final shift N -> done.
// Assumes N >= 4 and P >= 1. The step counter counts shift clocks.
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int N  = 8,
    parameter int P  = 4,
    parameter int CW = $clog2(N),
    parameter int IW = $clog2(P + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output phase_t        phase_o,
    output logic [CW-1:0] cnt_o,
    output logic [IW-1:0] pat_idx_o,
    output logic [IW-1:0] unl_idx_o,
    output logic          launch_o
);
    localparam logic [CW-1:0] LAST  = CW'(N - 1);
    localparam logic [IW-1:0] NPAT  = IW'(P);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic [IW-1:0] pat_idx;
    logic [IW-1:0] unl_idx;

    // A start is taken only when no run is in progress.
    assign launch_o = start && (phase == PH_IDLE || phase == PH_DONE);

    // Phase, step counter and pattern indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            pat_idx <= '0;
            unl_idx <= '0;
        end else begin
            case (phase)
                PH_IDLE, PH_DONE: begin
                    if (launch_o) begin
                        phase   <= PH_FILL;
                        cnt     <= '0;
                        pat_idx <= '0;
                        unl_idx <= NPAT;
                    end
                end
                PH_FILL: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        phase <= PH_SHIFT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SHIFT: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        phase <= (pat_idx < NPAT) ? PH_CAPT : PH_DONE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CAPT: begin
                    phase   <= PH_SHIFT;
                    unl_idx <= pat_idx;
                    pat_idx <= pat_idx + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign phase_o   = phase;
    assign cnt_o     = cnt;
    assign pat_idx_o = pat_idx;
    assign unl_idx_o = unl_idx;
endmodule

// File: rtl/scan_cmp.sv
`timescale 1ns/1ps
// Response comparator. It latches the expected response in the capture
// clock and compares the scan-out bit in every shift clock. The first
// mismatch is kept. Index P marks the flush unload.
module scan_cmp
    import scan_pkg::*;
#(
    parameter int N  = 8,
    parameter int P  = 4,
    parameter int CW = $clog2(N),
    parameter int IW = $clog2(P + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          capt,
    input  logic          shift,
    input  logic [CW-1:0] cnt,
    input  logic [IW-1:0] unl_idx,
    input  logic          so,
    input  logic [N-1:0]  exp_i,
    output logic          fail_o,
    output logic [IW-1:0] fail_idx_o
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);
    localparam logic [IW-1:0] NPAT = IW'(P);

    logic [N-1:0]  exp_q;
    logic [CW-1:0] rev;
    logic          want;
    logic          miss;

    assign rev  = LAST - cnt;
    assign want = (unl_idx == NPAT) ? flush_bit(32'(cnt)) : exp_q[rev];
    assign miss = shift && (so != want);

    // Expected response, taken while the response is captured.
    always_ff @(posedge clk) begin
        if (!rst_n)    exp_q <= '0;
        else if (capt) exp_q <= exp_i;
    end

    // Sticky fail flag and the index of the first failing pattern.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fail_o     <= 1'b0;
            fail_idx_o <= '0;
        end else if (miss && !fail_o) begin
            fail_o     <= 1'b1;
            fail_idx_o <= unl_idx;
        end
    end
endmodule

// File: rtl/scan_seq_top.sv
`timescale 1ns/1ps
// Scan test sequencer top. The chain wraps the circuit under test, and the
// controller runs flush, load/capture/unload and the final unload. The
// pattern source must show stim_i, pi_i and exp_i for pat_idx_o.
module scan_seq_top
    import scan_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int NUM_PAT   = 4,
    parameter int PI_W      = 4,
    localparam int IW       = $clog2(NUM_PAT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CHAIN_LEN-1:0] stim_i,
    input  logic [PI_W-1:0]      pi_i,
    input  logic [CHAIN_LEN-1:0] exp_i,
    output logic                 scan_en_o,
    output logic                 scan_out_o,
    output logic [IW-1:0]        pat_idx_o,
    output logic                 done_o,
    output logic                 fail_o,
    output logic [IW-1:0]        fail_idx_o
);
    localparam int CW = $clog2(CHAIN_LEN);
    localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);
    localparam logic [IW-1:0] NPAT = IW'(NUM_PAT);

    phase_t               phase;
    logic [CW-1:0]        cnt;
    logic [IW-1:0]        pat_idx;
    logic [IW-1:0]        unl_idx;
    logic                 launch;
    logic                 se, en, si, busy;
    logic [CHAIN_LEN-1:0] chain_q, cut_y;
    logic [CW-1:0]        rev;

    scan_ctrl #(.N(CHAIN_LEN), .P(NUM_PAT), .CW(CW), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .phase_o(phase), .cnt_o(cnt), .pat_idx_o(pat_idx),
        .unl_idx_o(unl_idx), .launch_o(launch)
    );

    assign se   = (phase == PH_FILL) || (phase == PH_SHIFT);
    assign en   = se || (phase == PH_CAPT);
    assign busy = en;
    assign rev  = LAST - cnt;

    // Scan-in source: the flush sequence, then the stimulus MSB first, then zeros.
    always_comb begin
        if (phase == PH_FILL)     si = flush_bit(32'(cnt));
        else if (pat_idx < NPAT)  si = stim_i[rev];
        else                      si = 1'b0;
    end

    scan_cut #(.N(CHAIN_LEN), .PW(PI_W)) u_cut (
        .s(chain_q), .pi(pi_i), .y(cut_y)
    );

    scan_chain #(.N(CHAIN_LEN)) u_chain (
        .clk(clk), .rst_n(rst_n), .en(en), .se(se), .si(si),
        .d(cut_y), .q(chain_q), .so(scan_out_o)
    );

    scan_cmp #(.N(CHAIN_LEN), .P(NUM_PAT), .CW(CW), .IW(IW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(launch),
        .capt(phase == PH_CAPT), .shift(phase == PH_SHIFT),
        .cnt(cnt), .unl_idx(unl_idx), .so(scan_out_o), .exp_i(exp_i),
        .fail_o(fail_o), .fail_idx_o(fail_idx_o)
    );

    assign scan_en_o = se;
    assign pat_idx_o = pat_idx;
    assign done_o    = (phase == PH_DONE);
endmodule

// File: rtl/scan_seq_chk.sv
`timescale 1ns/1ps
// Assertion checker for scan_seq_top, attached with the bind below.
module scan_seq_chk #(
    parameter int N  = 8,
    parameter int P  = 4,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          launch,
    input logic          busy,
    input logic          scan_en,
    input logic          scan_out,
    input logic          done,
    input logic          fail,
    input logic [IW-1:0] fail_idx,
    input logic [IW-1:0] pat_idx
);
    int  hi_run;
    logic capt;
    assign capt = busy && !scan_en;

    // Count consecutive scan-enable clocks before each capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_run <= 0;
        else if (scan_en) hi_run <= hi_run + 1;
        else              hi_run <= 0;
    end

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> scan_en && !done && !fail);
    p_shift_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capt |-> (hi_run == N || hi_run == 2 * N));
    p_capt_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capt |=> scan_en);
    p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capt |=> pat_idx == IW'($past(pat_idx) + 1'b1));
    p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pat_idx <= IW'(P));
    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !launch |=> fail && $stable(fail_idx));
    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !scan_en && !busy);
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !launch |=> done && $stable(scan_out));
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !launch);
endmodule

bind scan_seq_top scan_seq_chk #(.N(CHAIN_LEN), .P(NUM_PAT), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy),
    .scan_en(scan_en_o), .scan_out(scan_out_o), .done(done_o),
    .fail(fail_o), .fail_idx(fail_idx_o), .pat_idx(pat_idx_o)
);

// File: tb/sim_scan_seq_top.sv
`timescale 1ns/1ps
// Bench: a behavioural queue model of the chain, stepped and compared every clock.
module sim_scan_seq_top;
    localparam int N  = 6;
    localparam int P  = 3;
    localparam int PW = 3;
    localparam int IW = $clog2(P + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, start;
    logic [N-1:0]  stim_i, exp_i;
    logic [PW-1:0] pi_i;
    logic          scan_en_o, scan_out_o, done_o, fail_o;
    logic [IW-1:0] pat_idx_o, fail_idx_o;

    scan_seq_top #(.CHAIN_LEN(N), .NUM_PAT(P), .PI_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .stim_i(stim_i),
        .pi_i(pi_i), .exp_i(exp_i), .scan_en_o(scan_en_o),
        .scan_out_o(scan_out_o), .pat_idx_o(pat_idx_o), .done_o(done_o),
        .fail_o(fail_o), .fail_idx_o(fail_idx_o)
    );

    int bad_mask = 0;
    int nchk = 0, nfail = 0;
    bit finished = 0;

    function automatic logic [N-1:0] stim_of(input int k);
        return N'(32'h2D ^ (k * 37));
    endfunction
    function automatic logic [PW-1:0] pi_of(input int k);
        return PW'(k * 5 + 3);
    endfunction
    function automatic logic [N-1:0] resp_of(input logic [N-1:0] s, input logic [PW-1:0] p);
        logic [N-1:0] y;
        for (int i = 0; i < N; i++)
            y[i] = (s[(i + 1) % N] & p[i % PW]) ^ s[(i + N - 1) % N];
        return y;
    endfunction
    function automatic logic [N-1:0] exp_of(input int k);
        logic [N-1:0] g = resp_of(stim_of(k), pi_of(k));
        return bad_mask[k] ? (g ^ N'(1)) : g;
    endfunction

    always_comb begin
        stim_i = stim_of(int'(pat_idx_o));
        pi_i   = pi_of(int'(pat_idx_o));
        exp_i  = exp_of(int'(pat_idx_o));
    end

    // Reference model state.
    bit mq[$];
    bit busy = 0, mdone = 0, mfail = 0;
    int t = 0, midx = 0, mfidx = 0;

    task automatic chk(input string tag, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0d)", tag, act, expv, t);
        end
    endtask

    // One clock: compare at the falling edge, drive start, advance the model.
    task automatic cycle(input logic st);
        int ph, blk, off, u;
        bit o, e, si;
        bit nq[N];
        logic [N-1:0] v;
        @(negedge clk);
        blk = 0; off = 0;
        if (!busy) ph = 0;
        else if (t < N) begin ph = 1; off = t; end
        else begin
            blk = (t - N) / (N + 1);
            off = (t - N) % (N + 1);
            ph = (blk < P && off == N) ? 3 : 2;
        end
        chk(ph == 1 ? "R2" : "R5", int'(scan_en_o), int'(ph == 1 || ph == 2));
        chk(!busy ? "R9" : (ph == 2 && blk == 0) ? "R3" : "R6 (R4 load order)",
            int'(scan_out_o), int'(mq[N-1]));
        chk("R7", int'(pat_idx_o), midx);
        chk("R9", int'(done_o), int'(mdone));
        chk("R8", int'(fail_o), int'(mfail));
        chk("R8", int'(fail_idx_o), mfidx);
        start = st;
        if (!busy) begin
            if (st) begin
                busy = 1; t = 0; mfail = 0; mfidx = 0; mdone = 0; midx = 0;
            end
        end else begin
            case (ph)
                1: begin
                    si = bit'((off >> 1) & 1);
                    void'(mq.pop_back()); mq.push_front(si);
                end
                2: begin
                    o = mq[N-1];
                    u = (blk == 0) ? P : blk - 1;
                    if (u == P) e = bit'((off >> 1) & 1);
                    else begin v = exp_of(u); e = v[N-1-off]; end
                    if (o != e && !mfail) begin mfail = 1; mfidx = u; end
                    if (blk < P) begin v = stim_of(blk); si = v[N-1-off]; end
                    else si = 0;
                    void'(mq.pop_back()); mq.push_front(si);
                    if (blk == P && off == N - 1) begin busy = 0; mdone = 1; end
                end
                default: begin
                    for (int i = 0; i < N; i++)
                        nq[i] = (mq[(i + 1) % N] & pi_of(blk)[i % PW]) ^ mq[(i + N - 1) % N];
                    for (int i = 0; i < N; i++) mq[i] = nq[i];
                    midx = blk + 1;
                end
            endcase
            t++;
        end
    endtask

    task automatic run(input int bad, input int poke, input bit efail, input int eidx);
        bad_mask = bad;
        cycle(1'b1);
        cycle(1'b0);
        chk("R11 fail cleared at start", int'(fail_o), 0);
        chk("R11 done cleared at start", int'(done_o), 0);
        while (busy) begin
            cycle(t == poke);
            if (t == poke + 1) chk("R10 start ignored", int'(scan_en_o), 1);
        end
        repeat (3) cycle(1'b0);
        chk("R8 final fail", int'(fail_o), int'(efail));
        chk("R8 fail index", int'(fail_idx_o), eidx);
        chk("R9 done held", int'(done_o), 1);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0;
        for (int i = 0; i < N; i++) mq.push_back(1'b0);
        repeat (3) @(negedge clk);
        chk("R1 scan_en", int'(scan_en_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 fail", int'(fail_o), 0);
        chk("R1 pat_idx", int'(pat_idx_o), 0);
        chk("R1 fail_idx", int'(fail_idx_o), 0);
        rst_n = 1'b1;
        repeat (2) cycle(1'b0);
        run(0, 9, 0, 0);
        run(32'b010, 3, 1, 1);
        run(32'b101, 20, 1, 0);
        run(32'b100, 30, 1, 2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule